// File: doc/BRIEF.md
# Register-driven MDIO management master

This block lets a processor reach the 16-bit registers of an attached physical-layer device over the two-wire management bus (MDC clock, bidirectional MDIO data). Software sees two 16-bit registers: a command register and a data register. It places write data in the data register if needed. One write to the command register then names the device, the register inside it and the direction. That write starts a complete serial frame on the bus.

While the frame is running, a busy flag in the command register reads as one. Writes from the host to either register are dropped until the flag clears. On a read, the sixteen bits returned by the device replace the contents of the data register, and they are valid when the busy flag reads zero. MDC is produced by dividing the system clock. MDIO is driven through an output plus an output-enable, so a pad-level tristate can be built outside the block.

The host side is a plain register port. Each access completes in one cycle and there is no back-pressure. Guarding against writes during busy is done inside the block, not by stalling the host.

Top module: `mdio_host_master`

## Requirements
- R1: After a synchronous active-low reset both read ports are zero, busy reads 0, MDC is low and MDIO output enable is low.
- R2: Command register layout: bits [4:0] device register number, bits [9:5] device address, bit 10 direction (1 = write, 0 = read), bits [14:11] read as 0, bit 15 busy (read-only). Accepted fields read back unchanged.
- R3: An accepted command write sets busy, and busy is seen in the cycle right after the write.
- R4: Each frame is sent MSB first as 32 ones, then start code 01, then opcode 10 for read or 01 for write, then the 5-bit device address, then the 5-bit register number.
- R5: In a write frame the block sends turnaround bits 10 and then the 16 bits of the data register, driving MDIO for all 64 bit times.
- R6: In a read frame MDIO is released (output enable low) for bit times 46..63, which are the turnaround and data bits. The 16 bits sampled at MDC rising edges are placed in the data register, MSB first, and are readable when busy clears.
- R7: While a frame runs, MDC has a period of 2*DIV_HALF system clocks. MDIO output and output enable change only where MDC falls. When idle, MDC is low.
- R8: Host writes to either register while busy is 1 are ignored. The frame in progress, the command fields and the data register are left unchanged.
- R9: Busy reads 1 for exactly 1 + 128*DIV_HALF system clock cycles per frame, and afterwards MDIO is released with MDC low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Host write data |
| ctrl_rdata | output | 16 | Command register read value, busy in bit 15 |
| data_rdata | output | 16 | Data register read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with DIV_HALF = 3. This gives an odd divider that is not a power of two, so the wrap of the divider counter and the length of an MDC half period are both tested without cycles going unchecked. A frame at this setting takes 385 cycles. That is short enough to run write frames, read frames with boundary addresses, and an attempt to disturb the block while busy, all against a device responder that records every bit on each MDC rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last      = (cnt == CW'(DIV_HALF - 1));
  assign rise_tick = run && last && !mdc;
  assign fall_tick = run && last && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc) else $error("mdc high while idle"); // R7
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  mdio_cmd_t  cmd,
  input  logic [15:0] wdata,
  input  logic       rise_tick,
  input  logic       fall_tick,
  input  logic       mdio_i,
  output logic       busy,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic       rd_done,
  output logic [15:0] rd_value
);
  eng_state_t                state;
  logic [FRAME_BITS-1:0]     shreg;
  logic [IDX_W-1:0]          idx;
  logic                      is_rd;
  logic [15:0]               cap;
  logic                      last_fall;

  assign busy      = (state == ENG_SHIFT);
  assign last_fall = busy && fall_tick && (idx == IDX_W'(FRAME_BITS - 1));
  assign rd_done   = last_fall && is_rd;
  assign rd_value  = cap;
  assign mdio_oe   = busy && !(is_rd && (idx >= IDX_W'(TA_FIRST)));
  assign mdio_o    = mdio_oe && shreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      shreg <= '0;
      idx   <= '0;
      is_rd <= 1'b0;
      cap   <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            shreg <= {32'hFFFF_FFFF, 2'b01,
                      (cmd.wr ? 2'b01 : 2'b10),
                      cmd.phy, cmd.regad,
                      (cmd.wr ? 2'b10 : 2'b00),
                      (cmd.wr ? wdata : 16'h0000)};
            idx   <= '0;
            is_rd <= !cmd.wr;
            state <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (rise_tick && is_rd && (idx >= IDX_W'(DATA_FIRST)))
            cap <= {cap[14:0], mdio_i};
          if (fall_tick) begin
            if (idx == IDX_W'(FRAME_BITS - 1)) begin
              state <= ENG_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(last_fall) |-> $stable(is_rd)) else $error("direction changed mid-frame"); // R8
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  input  logic        eng_busy,
  input  logic        rd_done,
  input  logic [15:0] rd_value,
  output mdio_cmd_t   cmd,
  output logic [15:0] data_q,
  output logic        start,
  output logic [15:0] ctrl_rdata
);
  logic host_busy;
  logic accept;

  assign host_busy  = eng_busy || start;
  assign accept     = reg_wr && !host_busy;
  assign ctrl_rdata = {host_busy, 4'b0000, cmd.wr, cmd.phy, cmd.regad};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd    <= '0;
      data_q <= '0;
      start  <= 1'b0;
    end else begin
      start <= accept && !reg_sel;
      if (accept && !reg_sel) begin
        cmd.regad <= reg_wdata[4:0];
        cmd.phy   <= reg_wdata[9:5];
        cmd.wr    <= reg_wdata[10];
      end
      if (accept && reg_sel)
        data_q <= reg_wdata;
      else if (rd_done)
        data_q <= rd_value;
    end
  end

  AST_DATA_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && $past(eng_busy) && !$past(rd_done) |-> $stable(data_q)) else $error("data changed while busy"); // R8
  AST_CMD_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && $past(eng_busy) |-> $stable(cmd)) else $error("command changed while busy"); // R8
endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t   cmd;
  logic [15:0] data_q;
  logic [15:0] rd_value;
  logic        start;
  logic        eng_busy;
  logic        rd_done;
  logic        rise_tick;
  logic        fall_tick;

  assign data_rdata = data_q;

  mdio_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .eng_busy  (eng_busy),
    .rd_done   (rd_done),
    .rd_value  (rd_value),
    .cmd       (cmd),
    .data_q    (data_q),
    .start     (start),
    .ctrl_rdata(ctrl_rdata)
  );

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (eng_busy),
    .mdc      (mdc),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd),
    .wdata    (data_q),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_value (rd_value)
  );

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> eng_busy) else $error("start did not raise busy"); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[15] |-> !mdio_oe && !mdc) else $error("bus not released in idle"); // R9
  AST_MDIO_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && $past(eng_busy) && mdc |-> $stable(mdio_o) && $stable(mdio_oe)) else $error("mdio moved while mdc high"); // R7
endmodule

// File: tb/mdio_host_master_tb.sv
module mdio_host_master_tb;
  localparam int DIV_HALF = 3;
  localparam int BUSY_CYC = 1 + 128 * DIV_HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic [15:0] data_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  mdio_host_master #(.DIV_HALF(DIV_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // device responder: records each bit at MDC rise, drives read data after it
  int          k = 0;
  logic [63:0] cap_o;
  logic [63:0] cap_oe;
  logic [15:0] resp = '0;
  time         last_rise = 0;
  int          per_err = 0;

  always @(posedge mdc) begin
    if (k > 0 && ($time - last_rise) != time'(2 * DIV_HALF * 8)) per_err++;
    last_rise = $time;
    if (k < 64) begin
      cap_o[63-k]  = mdio_o;
      cap_oe[63-k] = mdio_oe;
    end
    k++;
    #1;
    if (k >= 48 && k < 64) mdio_i = resp[63-k];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_write(input bit sel, input logic [15:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (ctrl_rdata[15] && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] ctrl_word(input bit wr, input logic [4:0] phy, input logic [4:0] rg);
    return {5'b0, wr, phy, rg};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rdata == 16'h0 && data_rdata == 16'h0, "R1 regs zero", {ctrl_rdata, data_rdata}, 64'h0);
    chk(!mdc && !mdio_oe, "R1 bus idle", {mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_write_frame(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] exp;
    int n;
    host_write(1'b1, d);
    chk(data_rdata == d, "R2 data register write", data_rdata, d);
    k = 0; per_err = 0;
    host_write(1'b0, ctrl_word(1'b1, phy, rg));
    chk(ctrl_rdata[15] == 1'b1, "R3 busy after write", ctrl_rdata, 64'h1);
    wait_idle(n);
    chk(n == BUSY_CYC, "R9 busy length", n, BUSY_CYC);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    chk(k == 64, "R4 bit count", k, 64);
    chk(cap_o[63:18] == exp[63:18], "R4 header bits", cap_o[63:18], exp[63:18]);
    chk(cap_o[17:0] == exp[17:0], "R5 turnaround and data", cap_o[17:0], exp[17:0]);
    chk(cap_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R5 driven throughout", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(per_err == 0, "R7 mdc period", per_err, 0);
    chk(ctrl_rdata == ctrl_word(1'b1, phy, rg), "R2 readback fields", ctrl_rdata, ctrl_word(1'b1, phy, rg));
    chk(!mdc && !mdio_oe, "R9 released after frame", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_read_frame(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] r);
    logic [63:0] exp;
    int n;
    resp = r; k = 0; per_err = 0;
    host_write(1'b0, ctrl_word(1'b0, phy, rg));
    chk(ctrl_rdata[15] == 1'b1, "R3 busy on read", ctrl_rdata, 64'h1);
    wait_idle(n);
    chk(n == BUSY_CYC, "R9 busy length read", n, BUSY_CYC);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 18'h0};
    chk(cap_o[63:18] == exp[63:18], "R4 read header", cap_o[63:18], exp[63:18]);
    chk(cap_oe == 64'hFFFF_FFFF_FFFC_0000, "R6 release window", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
    chk(data_rdata == r, "R6 captured data", data_rdata, r);
    chk(per_err == 0, "R7 mdc period read", per_err, 0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] exp;
    int n;
    host_write(1'b1, 16'h1234);
    k = 0;
    host_write(1'b0, ctrl_word(1'b1, 5'h01, 5'h02));
    repeat (50) @(negedge clk);
    host_write(1'b0, ctrl_word(1'b0, 5'h03, 5'h1F));
    host_write(1'b1, 16'hFFFF);
    chk(ctrl_rdata == {1'b1, ctrl_word(1'b1, 5'h01, 5'h02)[14:0]}, "R8 ctrl unchanged", ctrl_rdata,
        {1'b1, ctrl_word(1'b1, 5'h01, 5'h02)[14:0]});
    chk(data_rdata == 16'h1234, "R8 data unchanged", data_rdata, 16'h1234);
    wait_idle(n);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 16'h1234};
    chk(cap_o == exp, "R8 frame undisturbed", cap_o, exp);
    chk(data_rdata == 16'h1234, "R8 data after frame", data_rdata, 16'h1234);
  endtask

  initial begin
    t_reset();
    t_write_frame(5'h11, 5'h07, 16'hBEEF);
    t_read_frame(5'h1F, 5'h00, 16'h5A3C);
    t_read_frame(5'h00, 5'h1F, 16'h8001);
    t_busy_ignore();
    t_write_frame(5'h00, 5'h00, 16'h0000);
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule